// File: doc/BRIEF.md
# Parallel Clause Implication Cell Array

This block is the implication fabric of a hardware satisfiability search. Each variable of a small, fixed CNF formula is held as a two-rail literal pair. The first rail means "known true" and the second means "known false". A clause module watches the three literals of one clause. For each literal it raises an implication when the other two are already known false. A per-variable cell collects every implication aimed at its true rail or its false rail, merges in the value the search controller has assigned by branching, and registers the result.

Implied values are registered, so implication spreads by one clause level on every clock edge and no combinational loop can form. Each cell also reports two flags. The change flag says its pair is about to take a new value. The conflict flag says both of its rails are set. The array ORs these flags into global change and conflict outputs. A controller waits until global change falls before it continues the search. When it backtracks, it pulses the global clear to wipe every implied value.

The example formula has six variables x1..x6 and four clauses: (x1 | ~x2 | ~x3), (x1 | x2 | ~x4), (~x1 | x2 | x5), (~x1 | ~x4 | ~x6). Bit i of every per-variable vector belongs to variable x(i+1).

Top module: `impl_array`

## Requirements
- R1: A variable is a pair (pos, neg). (0,0) is unknown, (1,0) is true, (0,1) is false and (1,1) is a conflict. `val_pos[i]` and `val_neg[i]` give the registered pair of x(i+1).
- R2: A literal is implied by a clause when the other two literals of that clause are known false. A positive literal of x is false when x.neg is 1. A negated literal of x is false when x.pos is 1. The implication sets x.pos for a positive literal and x.neg for a negated one.
- R3: A rail's next value is the OR of the implications from every clause in which that literal appears.
- R4: `asg_pos[i]` and `asg_neg[i]` are ORed into the next value of the matching rail. Assignment alone makes the rail 1 after the next edge.
- R5: Pairs are registered, so a chain of implications advances by one clause per clock edge.
- R6: `lchange[i]` is 1 exactly when the pair that x(i+1) will load at the next edge differs from its current pair in either rail.
- R7: `lconflict[i]` is 1 exactly when both registered rails of x(i+1) are 1.
- R8: When `gclear` is 1, every pair loads (0,0) at the next edge. This takes priority over implications and assignments in the same cycle.
- R9: The synchronous active-high `rst` loads (0,0) into every pair at the next edge, whatever the other inputs are.
- R10: `gchange` is the OR of all `lchange` bits and `gconflict` is the OR of all `lconflict` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gclear | input | 1 | Global clear of all implied values |
| asg_pos | input | 6 | Branch-assigned true rail, one bit per variable |
| asg_neg | input | 6 | Branch-assigned false rail, one bit per variable |
| val_pos | output | 6 | Registered true rails |
| val_neg | output | 6 | Registered false rails |
| lchange | output | 6 | Per-variable change flags |
| lconflict | output | 6 | Per-variable conflict flags |
| gchange | output | 1 | OR of all change flags |
| gconflict | output | 1 | OR of all conflict flags |

## Verification
The assertions assume that `rst` is either held or released on clock edges and that the assignment and clear inputs are stable around each rising edge. The bench changes every input only on falling edges. The stimulus goes through all 4096 combinations of the twelve assignment bits. Each combination starts from a cleared array, is held for three edges so that implication chains can settle or reach a conflict, and is then cleared while the assignment is still held. This stresses clear priority. Directed runs cover the reset state, a reset applied while every rail is driven, and a three-level implication chain checked edge by edge.

// File: rtl/impl_pkg.sv
package impl_pkg;

  localparam int NVAR = 6;
  localparam int NCLS = 4;
  localparam int CLW  = 3;

  typedef struct packed {
    logic pos;
    logic neg;
  } lpair_t;

  localparam lpair_t LP_FREE = '{pos: 1'b0, neg: 1'b0};

  // literal of a variable is known false: positive literal -> neg rail set,
  // negated literal -> pos rail set
  function automatic logic lit_false(lpair_t p, logic positive);
    return positive ? p.neg : p.pos;
  endfunction

  // pair loaded at the next edge from gathered terms
  function automatic lpair_t pair_next(logic any_pos, logic any_neg,
                                       logic a_pos, logic a_neg,
                                       logic clr);
    lpair_t r;
    r.pos = (any_pos | a_pos) & ~clr;
    r.neg = (any_neg | a_neg) & ~clr;
    return r;
  endfunction

  function automatic logic pair_differs(lpair_t a, lpair_t b);
    return ((a.pos ^ b.pos) | (a.neg ^ b.neg));
  endfunction

endpackage

// File: rtl/clause_imp.sv
module clause_imp
  import impl_pkg::*;
#(
  parameter int          NLIT = CLW,
  parameter logic [NLIT-1:0] POL = '1
) (
  input  lpair_t [NLIT-1:0] lits,
  output logic   [NLIT-1:0] imp
);

  logic [NLIT-1:0] fls;

  generate
    for (genvar j = 0; j < NLIT; j++) begin : g_false
      assign fls[j] = lit_false(lits[j], POL[j]);
    end
    for (genvar k = 0; k < NLIT; k++) begin : g_imp
      logic others_false;
      always_comb begin
        others_false = 1'b1;
        for (int j = 0; j < NLIT; j++) begin
          if (j != k) others_false = others_false & fls[j];
        end
      end
      assign imp[k] = others_false;
    end
  endgenerate

endmodule

// File: rtl/lit_cell.sv
module lit_cell
  import impl_pkg::*;
#(
  parameter int NPT = 1,
  parameter int NNT = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gclear,
  input  logic           asg_pos,
  input  logic           asg_neg,
  input  logic [NPT-1:0] pos_terms,
  input  logic [NNT-1:0] neg_terms,
  output lpair_t         lit,
  output logic           lchange,
  output logic           lconflict
);

  lpair_t nxt;
  logic   any_pos, any_neg;

  assign any_pos = |pos_terms;
  assign any_neg = |neg_terms;
  assign nxt     = pair_next(any_pos, any_neg, asg_pos, asg_neg, gclear);

  always_ff @(posedge clk) begin
    if (rst) lit <= LP_FREE;
    else     lit <= nxt;
  end

  assign lchange   = pair_differs(nxt, lit);
  assign lconflict = lit.pos & lit.neg;

  a_r8_clear_frees: assert property (@(posedge clk) disable iff (rst)
    gclear |=> (lit == LP_FREE));
  a_r9_reset_frees: assert property (@(posedge clk)
    rst |=> (lit == LP_FREE));
  a_r4_asg_pos: assert property (@(posedge clk) disable iff (rst)
    (asg_pos && !gclear) |=> lit.pos);
  a_r4_asg_neg: assert property (@(posedge clk) disable iff (rst)
    (asg_neg && !gclear) |=> lit.neg);
  a_r6_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    !lchange |=> $stable(lit));
  a_r7_both_assigned: assert property (@(posedge clk) disable iff (rst)
    (asg_pos && asg_neg && !gclear) |=> lconflict);

endmodule

// File: rtl/impl_array.sv
module impl_array
  import impl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            gclear,
  input  logic [NVAR-1:0] asg_pos,
  input  logic [NVAR-1:0] asg_neg,
  output logic [NVAR-1:0] val_pos,
  output logic [NVAR-1:0] val_neg,
  output logic [NVAR-1:0] lchange,
  output logic [NVAR-1:0] lconflict,
  output logic            gchange,
  output logic            gconflict
);

  lpair_t          cur [NVAR];
  logic [CLW-1:0]  c_imp [NCLS];

  // clause 0: (x1 | ~x2 | ~x3)
  clause_imp #(.NLIT(CLW), .POL(3'b001)) u_c0 (
    .lits ({cur[2], cur[1], cur[0]}), .imp (c_imp[0]));
  // clause 1: (x1 | x2 | ~x4)
  clause_imp #(.NLIT(CLW), .POL(3'b011)) u_c1 (
    .lits ({cur[3], cur[1], cur[0]}), .imp (c_imp[1]));
  // clause 2: (~x1 | x2 | x5)
  clause_imp #(.NLIT(CLW), .POL(3'b110)) u_c2 (
    .lits ({cur[4], cur[1], cur[0]}), .imp (c_imp[2]));
  // clause 3: (~x1 | ~x4 | ~x6)
  clause_imp #(.NLIT(CLW), .POL(3'b000)) u_c3 (
    .lits ({cur[5], cur[3], cur[0]}), .imp (c_imp[3]));

  // x1: positive in clauses 0,1; negated in clauses 2,3
  lit_cell #(.NPT(2), .NNT(2)) u_v1 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[0]), .asg_neg (asg_neg[0]),
    .pos_terms ({c_imp[0][0], c_imp[1][0]}),
    .neg_terms ({c_imp[2][0], c_imp[3][0]}),
    .lit (cur[0]), .lchange (lchange[0]), .lconflict (lconflict[0]));
  // x2: positive in clauses 1,2; negated in clause 0
  lit_cell #(.NPT(2), .NNT(1)) u_v2 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[1]), .asg_neg (asg_neg[1]),
    .pos_terms ({c_imp[1][1], c_imp[2][1]}),
    .neg_terms (c_imp[0][1]),
    .lit (cur[1]), .lchange (lchange[1]), .lconflict (lconflict[1]));
  // x3: negated in clause 0 only
  lit_cell #(.NPT(1), .NNT(1)) u_v3 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[2]), .asg_neg (asg_neg[2]),
    .pos_terms (1'b0),
    .neg_terms (c_imp[0][2]),
    .lit (cur[2]), .lchange (lchange[2]), .lconflict (lconflict[2]));
  // x4: negated in clauses 1,3
  lit_cell #(.NPT(1), .NNT(2)) u_v4 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[3]), .asg_neg (asg_neg[3]),
    .pos_terms (1'b0),
    .neg_terms ({c_imp[1][2], c_imp[3][1]}),
    .lit (cur[3]), .lchange (lchange[3]), .lconflict (lconflict[3]));
  // x5: positive in clause 2 only
  lit_cell #(.NPT(1), .NNT(1)) u_v5 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[4]), .asg_neg (asg_neg[4]),
    .pos_terms (c_imp[2][2]),
    .neg_terms (1'b0),
    .lit (cur[4]), .lchange (lchange[4]), .lconflict (lconflict[4]));
  // x6: negated in clause 3 only
  lit_cell #(.NPT(1), .NNT(1)) u_v6 (
    .clk, .rst, .gclear, .asg_pos (asg_pos[5]), .asg_neg (asg_neg[5]),
    .pos_terms (1'b0),
    .neg_terms (c_imp[3][2]),
    .lit (cur[5]), .lchange (lchange[5]), .lconflict (lconflict[5]));

  generate
    for (genvar i = 0; i < NVAR; i++) begin : g_out
      assign val_pos[i] = cur[i].pos;
      assign val_neg[i] = cur[i].neg;
    end
  endgenerate

  assign gchange   = |lchange;
  assign gconflict = |lconflict;

  a_r10_settled_holds: assert property (@(posedge clk) disable iff (rst)
    !gchange |=> ($stable(val_pos) && $stable(val_neg)));
  a_r10_conflict_seen: assert property (@(posedge clk) disable iff (rst)
    (|(val_pos & val_neg)) |-> gconflict);

endmodule

// File: tb/sim_impl_array.sv
module sim_impl_array;
  localparam int  NV  = 6;
  localparam time CLK = 10;

  logic clk = 1'b0;
  logic rst, gclear;
  logic [NV-1:0] asg_pos, asg_neg;
  logic [NV-1:0] val_pos, val_neg, lchange, lconflict;
  logic gchange, gconflict;

  int checks = 0;
  int errors = 0;

  // clause table: variable index and polarity (1 = positive literal)
  int cv [4][3] = '{'{0,1,2}, '{0,1,3}, '{0,1,4}, '{0,3,5}};
  bit cp [4][3] = '{'{1,0,0}, '{1,1,0}, '{0,1,1}, '{0,0,0}};

  logic [NV-1:0] mp, mn;  // model pairs

  always #(CLK/2) clk = ~clk;

  impl_array u0 (
    .clk, .rst, .gclear, .asg_pos, .asg_neg,
    .val_pos, .val_neg, .lchange, .lconflict, .gchange, .gconflict);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one-level implication over the clause table (R2, R3, R4, R8)
  task automatic model_next(output logic [NV-1:0] np, output logic [NV-1:0] nn);
    np = asg_pos;
    nn = asg_neg;
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3; k++) begin
        bit all_false = 1'b1;
        for (int j = 0; j < 3; j++) begin
          if (j != k) begin
            bit f = cp[c][j] ? mn[cv[c][j]] : mp[cv[c][j]];
            all_false = all_false & f;
          end
        end
        if (all_false) begin
          if (cp[c][k]) np[cv[c][k]] = 1'b1;
          else          nn[cv[c][k]] = 1'b1;
        end
      end
    end
    if (gclear || rst) begin
      np = '0;
      nn = '0;
    end
  endtask

  task automatic step(input logic [NV-1:0] ap, input logic [NV-1:0] an,
                      input logic clr, input logic rs);
    logic [NV-1:0] np, nn, ch;
    @(negedge clk);
    asg_pos = ap; asg_neg = an; gclear = clr; rst = rs;
    #1;
    model_next(np, nn);
    ch = (np ^ mp) | (nn ^ mn);
    if (!rs) begin
      chk("R6 lchange", lchange, ch);
      chk("R10 gchange", gchange, |ch);
    end
    @(posedge clk);
    mp = np; mn = nn;
    #1;
    chk("R2 R3 R4 R5 val_pos", val_pos, mp);
    chk("R2 R3 R4 R5 val_neg", val_neg, mn);
    chk("R1 R7 lconflict", lconflict, mp & mn);
    chk("R10 gconflict", gconflict, |(mp & mn));
  endtask

  initial begin
    #(CLK * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; gclear = 1'b0; asg_pos = '0; asg_neg = '0;
    mp = '0; mn = '0;
    repeat (2) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 reset val_pos", val_pos, '0);
    chk("R9 reset val_neg", val_neg, '0);
    chk("R9 reset lconflict", lconflict, '0);

    // R5 chain: x2,x3,x6 true -> x1 true (clause 0) -> x4 false (clause 3)
    step(6'b100110, 6'b000000, 1'b0, 1'b0);
    chk("R5 level0 x1 free", val_pos[0], 1'b0);
    step(6'b100110, 6'b000000, 1'b0, 1'b0);
    chk("R5 level1 x1 true", val_pos[0], 1'b1);
    chk("R5 level1 x4 not yet", val_neg[3], 1'b0);
    step(6'b100110, 6'b000000, 1'b0, 1'b0);
    chk("R5 level2 x4 false", val_neg[3], 1'b1);
    step(6'b100110, 6'b000000, 1'b0, 1'b0);
    chk("R6 settled", gchange, 1'b0);

    // R9 reset overrides held assignments
    step(6'h3f, 6'h3f, 1'b0, 1'b0);
    chk("R7 all conflict", lconflict, 6'h3f);
    step(6'h3f, 6'h3f, 1'b0, 1'b1);
    chk("R9 mid-run reset", {val_pos, val_neg}, 12'h000);
    step(6'h00, 6'h00, 1'b0, 1'b0);

    // exhaustive over all assignment patterns
    for (int a = 0; a < 4096; a++) begin
      logic [NV-1:0] ap, an;
      ap = a[5:0];
      an = a[11:6];
      step(6'h00, 6'h00, 1'b1, 1'b0);
      step(ap, an, 1'b0, 1'b0);
      step(ap, an, 1'b0, 1'b0);
      step(ap, an, 1'b0, 1'b0);
      step(ap, an, 1'b1, 1'b0);   // R8 clear wins over held assignment
      chk("R8 clear priority", {val_pos, val_neg}, 12'h000);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule